// File: doc/BRIEF.md
# Tag-Broadcast Dynamic Scheduler

This block is the scheduling core of an out-of-order execution pipeline for two classes of arithmetic operation: additions and multiplications. Instructions come in from an instruction queue one per cycle, strictly in program order. Each accepted instruction takes a free slot in the waiting pool of its class. Its source registers are looked up in a register status table. A source whose value is still being computed is renamed to the number of the slot that will produce it. The destination register is then marked as pending on the slot just taken.

A slot sends its operation to the functional unit of its class once both operand values are present and that unit is idle. There is one adder with a two-cycle latency and one multiplier with a four-cycle latency. Both are stubs that compute a truncated sum or product. A finished unit puts its slot number and its result on a single result bus. In that same cycle, every waiting slot and every pending register that names that slot picks up the value. Later independent work can therefore finish ahead of earlier dependent work. A read port shows the register table so that the architectural state can be observed.

Top module: `tsched_core`

## Requirements
- R1: After reset every register i holds the value i, is not pending and has tag 0; the result bus is idle and the queue is accepted for either class.
- R2: An instruction is taken only in a cycle where `iq_valid` and `iq_ready` are both high. `iq_ready` is low while every slot of the class selected by `iq_op` (0 = adder class, 1 = multiplier class) is occupied. A refused instruction leaves the register table untouched and is taken unchanged once a slot frees.
- R3: Adder slots carry tags 8, 9 and 10, and multiplier slots carry tags 11, 12 and 13. The lowest free slot of the class is taken, and its tag is shown on `iq_tag` in the accepting cycle. A slot becomes free again in the cycle after its result is broadcast.
- R4: In the cycle after an instruction is taken, its destination register reads as pending with a tag equal to the slot tag it was given.
- R5: A slot starts its unit only with both operands present and the unit idle. For an instruction taken at edge k with ready sources and an idle unit, the result is on the bus during the cycle after edge k+2 for an add and after edge k+4 for a multiply, and not before.
- R6: A broadcast carries the sum, or the low 16 bits of the product, of the operand values. After the capturing edge, every register pending on that tag reads back the value and is no longer pending.
- R7: A register pending on a different tag ignores a broadcast and keeps its pending state and tag, so a newer writer of the same register is never overwritten by an older one.
- R8: A source whose producer is broadcasting in the very cycle the instruction is taken receives the broadcast value directly and does not wait for that tag again.
- R9: When both units have results in the same cycle, the one with the lower slot tag uses the bus first. The other unit holds its result and tag and broadcasts in the next cycle.
- R10: Every broadcast value, and the final content of every register, equals what sequential execution of the accepted instructions in program order would produce, whatever the completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_valid | input | 1 | Head of the instruction queue holds an instruction |
| iq_op | input | 1 | Operation class: 0 add, 1 multiply |
| iq_dst | input | 3 | Destination register index |
| iq_src1 | input | 3 | First source register index |
| iq_src2 | input | 3 | Second source register index |
| iq_ready | output | 1 | A slot of the requested class is free; the head is taken at this edge |
| iq_tag | output | 4 | Slot tag the head instruction is given |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 4 | Tag of the slot whose result is on the bus |
| cdb_data | output | 16 | Result value on the bus |
| rd_idx | input | 3 | Register table read index |
| rd_busy | output | 1 | Selected register is pending |
| rd_tag | output | 4 | Producer tag of the selected register |
| rd_data | output | 16 | Value held by the selected register |

## Verification
The hardest states to reach from the ports are the two that depend on exact cycle alignment. One is a new instruction taken in the very cycle its source's producer is on the bus. The other is both units finishing in the same cycle. The stimulus gets there by working from the fixed unit latencies. A multiply is taken, the add is taken exactly two edges later so both results fall due together, and the dependent instruction is driven in the cycle where the delayed multiply result appears. A scoreboard keyed by slot tag compares every broadcast with a program-order reference model. Short chains that rewrite the same register then cover the stale-tag case.

// File: rtl/tsched_pkg.sv
`timescale 1ns/1ps
package tsched_pkg;

  parameter int unsigned TAG_W = 4;

  typedef logic [TAG_W-1:0] tag_t;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } op_e;

endpackage

// File: rtl/tsched_regstat.sv
`timescale 1ns/1ps
// Register status table: value, pending bit and producer tag per register.
module tsched_regstat
  import tsched_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_en,
  input  logic [IDX_W-1:0]  iss_dst,
  input  tag_t              iss_tag,
  input  logic [IDX_W-1:0]  src1_idx,
  input  logic [IDX_W-1:0]  src2_idx,
  output logic              s1_rdy,
  output logic [DATA_W-1:0] s1_data,
  output tag_t              s1_tag,
  output logic              s2_rdy,
  output logic [DATA_W-1:0] s2_data,
  output tag_t              s2_tag,
  input  logic              cdb_valid,
  input  tag_t              cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_busy,
  output tag_t              rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  logic              busy_q [NREG];
  tag_t              tag_q  [NREG];
  logic [DATA_W-1:0] data_q [NREG];

  logic              busy_d [NREG];
  tag_t              tag_d  [NREG];
  logic [DATA_W-1:0] data_d [NREG];
  logic              upd_en [NREG];

  // Source lookup with same-cycle bus bypass
  always_comb begin
    s1_tag  = tag_q[src1_idx];
    s2_tag  = tag_q[src2_idx];
    s1_rdy  = !busy_q[src1_idx] || (cdb_valid && (cdb_tag == tag_q[src1_idx]));
    s2_rdy  = !busy_q[src2_idx] || (cdb_valid && (cdb_tag == tag_q[src2_idx]));
    s1_data = busy_q[src1_idx] ? cdb_data : data_q[src1_idx];
    s2_data = busy_q[src2_idx] ? cdb_data : data_q[src2_idx];
  end

  always_comb begin
    rd_busy = busy_q[rd_idx];
    rd_tag  = tag_q[rd_idx];
    rd_data = data_q[rd_idx];
  end

  // Next state: broadcast capture first, a new writer overrides
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      busy_d[i] = busy_q[i];
      tag_d[i]  = tag_q[i];
      data_d[i] = data_q[i];
      upd_en[i] = 1'b0;
      if (cdb_valid && busy_q[i] && (tag_q[i] == cdb_tag)) begin
        busy_d[i] = 1'b0;
        data_d[i] = cdb_data;
        upd_en[i] = 1'b1;
      end
      if (iss_en && (iss_dst == IDX_W'(i))) begin
        busy_d[i] = 1'b1;
        tag_d[i]  = iss_tag;
        upd_en[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        busy_q[i] <= 1'b0;
        tag_q[i]  <= '0;
        data_q[i] <= DATA_W'(i);
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (upd_en[i]) begin
          busy_q[i] <= busy_d[i];
          tag_q[i]  <= tag_d[i];
          data_q[i] <= data_d[i];
        end
      end
    end
  end

  AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |=> busy_q[$past(iss_dst)] && (tag_q[$past(iss_dst)] == $past(iss_tag))); // R4

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && busy_q[g] && (tag_q[g] == cdb_tag) && !(iss_en && (iss_dst == IDX_W'(g))))
      |=> !busy_q[g] && (data_q[g] == $past(cdb_data))); // R6
    AST_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && busy_q[g] && (tag_q[g] != cdb_tag) && !(iss_en && (iss_dst == IDX_W'(g))))
      |=> busy_q[g] && $stable(tag_q[g])); // R7
  end

endmodule

// File: rtl/tsched_rs_bank.sv
`timescale 1ns/1ps
// Waiting slots for one unit class: allocation, operand capture, dispatch pick.
module tsched_rs_bank
  import tsched_pkg::*;
#(
  parameter int NST    = 3,
  parameter int BASE   = 8,
  parameter int DATA_W = 16,
  localparam int SW    = (NST > 1) ? $clog2(NST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              a1_rdy,
  input  logic [DATA_W-1:0] a1_data,
  input  tag_t              a1_tag,
  input  logic              a2_rdy,
  input  logic [DATA_W-1:0] a2_data,
  input  tag_t              a2_tag,
  output logic              has_free,
  output tag_t              free_tag,
  input  logic              cdb_valid,
  input  tag_t              cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              unit_free,
  output logic              disp_en,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output tag_t              disp_tag
);

  logic              busy_q [NST];
  logic              sent_q [NST];
  logic              v1_q   [NST];
  logic              v2_q   [NST];
  logic [DATA_W-1:0] d1_q   [NST];
  logic [DATA_W-1:0] d2_q   [NST];
  tag_t              t1_q   [NST];
  tag_t              t2_q   [NST];

  logic              busy_d [NST];
  logic              sent_d [NST];
  logic              v1_d   [NST];
  logic              v2_d   [NST];
  logic [DATA_W-1:0] d1_d   [NST];
  logic [DATA_W-1:0] d2_d   [NST];
  tag_t              t1_d   [NST];
  tag_t              t2_d   [NST];
  logic              st_en  [NST];

  logic [SW-1:0] free_idx;
  logic [SW-1:0] disp_idx;
  logic          ready_any;

  // Lowest free slot and lowest ready slot
  always_comb begin
    has_free  = 1'b0;
    free_idx  = '0;
    ready_any = 1'b0;
    disp_idx  = '0;
    for (int i = NST - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        has_free = 1'b1;
        free_idx = SW'(i);
      end
      if (busy_q[i] && !sent_q[i] && v1_q[i] && v2_q[i]) begin
        ready_any = 1'b1;
        disp_idx  = SW'(i);
      end
    end
  end

  assign free_tag = TAG_W'(BASE) + TAG_W'(free_idx);
  assign disp_en  = unit_free && ready_any;
  assign disp_a   = d1_q[disp_idx];
  assign disp_b   = d2_q[disp_idx];
  assign disp_tag = TAG_W'(BASE) + TAG_W'(disp_idx);

  always_comb begin
    for (int i = 0; i < NST; i++) begin
      busy_d[i] = busy_q[i];
      sent_d[i] = sent_q[i];
      v1_d[i]   = v1_q[i];
      v2_d[i]   = v2_q[i];
      d1_d[i]   = d1_q[i];
      d2_d[i]   = d2_q[i];
      t1_d[i]   = t1_q[i];
      t2_d[i]   = t2_q[i];
      st_en[i]  = 1'b0;
      if (busy_q[i] && !v1_q[i] && cdb_valid && (t1_q[i] == cdb_tag)) begin
        v1_d[i]  = 1'b1;
        d1_d[i]  = cdb_data;
        st_en[i] = 1'b1;
      end
      if (busy_q[i] && !v2_q[i] && cdb_valid && (t2_q[i] == cdb_tag)) begin
        v2_d[i]  = 1'b1;
        d2_d[i]  = cdb_data;
        st_en[i] = 1'b1;
      end
      if (disp_en && (disp_idx == SW'(i))) begin
        sent_d[i] = 1'b1;
        st_en[i]  = 1'b1;
      end
      if (busy_q[i] && cdb_valid && (cdb_tag == TAG_W'(BASE + i))) begin
        busy_d[i] = 1'b0;
        st_en[i]  = 1'b1;
      end
      if (alloc_en && !busy_q[i] && (free_idx == SW'(i))) begin
        busy_d[i] = 1'b1;
        sent_d[i] = 1'b0;
        v1_d[i]   = a1_rdy;
        d1_d[i]   = a1_data;
        t1_d[i]   = a1_tag;
        v2_d[i]   = a2_rdy;
        d2_d[i]   = a2_data;
        t2_d[i]   = a2_tag;
        st_en[i]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) begin
        busy_q[i] <= 1'b0;
        sent_q[i] <= 1'b0;
        v1_q[i]   <= 1'b0;
        v2_q[i]   <= 1'b0;
        d1_q[i]   <= '0;
        d2_q[i]   <= '0;
        t1_q[i]   <= '0;
        t2_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NST; i++) begin
        if (st_en[i]) begin
          busy_q[i] <= busy_d[i];
          sent_q[i] <= sent_d[i];
          v1_q[i]   <= v1_d[i];
          v2_q[i]   <= v2_d[i];
          d1_q[i]   <= d1_d[i];
          d2_q[i]   <= d2_d[i];
          t1_q[i]   <= t1_d[i];
          t2_q[i]   <= t2_d[i];
        end
      end
    end
  end

  AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> has_free); // R2

  for (genvar g = 0; g < NST; g++) begin : g_chk
    AST_REL_ONLY_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && (cdb_tag == TAG_W'(BASE + g))) |-> busy_q[g] && sent_q[g]); // R5
  end

endmodule

// File: rtl/tsched_fu.sv
`timescale 1ns/1ps
// Fixed-latency functional unit stub with result hold while the bus is denied.
module tsched_fu
  import tsched_pkg::*;
#(
  parameter int LAT    = 2,
  parameter bit IS_MUL = 1'b0,
  parameter int DATA_W = 16,
  localparam int CW    = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  tag_t              op_tag,
  input  logic              grant,
  output logic              free,
  output logic              req,
  output logic [DATA_W-1:0] res,
  output tag_t              res_tag
);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] a_q, b_q;
  tag_t              tag_q;
  logic              ld_en;

  assign free  = (cnt_q == '0);
  assign req   = (cnt_q == CW'(1));
  assign ld_en = start && free;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en) begin
      cnt_d = CW'(LAT);
    end else if (req && grant) begin
      cnt_d = '0;
    end else if (cnt_q > CW'(1)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      tag_q <= '0;
    end else if (ld_en) begin
      a_q   <= op_a;
      b_q   <= op_b;
      tag_q <= op_tag;
    end
  end

  if (IS_MUL) begin : g_mul
    logic [2*DATA_W-1:0] prod;
    assign prod = {{DATA_W{1'b0}}, a_q} * {{DATA_W{1'b0}}, b_q};
    assign res  = prod[DATA_W-1:0];
  end else begin : g_add
    assign res = a_q + b_q;
  end

  assign res_tag = tag_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0)); // R5
  AST_HOLD_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> req && $stable(res) && $stable(res_tag)); // R9

endmodule

// File: rtl/tsched_core.sv
`timescale 1ns/1ps
// Top: in-order issue, two slot banks, two units, one result bus.
module tsched_core
  import tsched_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int DATA_W   = 16,
  parameter int ADD_RS   = 3,
  parameter int MUL_RS   = 3,
  parameter int ADD_BASE = 8,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 4,
  localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int MUL_BASE = ADD_BASE + ADD_RS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iq_valid,
  input  logic              iq_op,
  input  logic [IDX_W-1:0]  iq_dst,
  input  logic [IDX_W-1:0]  iq_src1,
  input  logic [IDX_W-1:0]  iq_src2,
  output logic              iq_ready,
  output logic [TAG_W-1:0]  iq_tag,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_busy,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  logic              s1_rdy, s2_rdy;
  logic [DATA_W-1:0] s1_data, s2_data;
  tag_t              s1_tag, s2_tag;

  logic              add_free_slot, mul_free_slot;
  tag_t              add_free_tag, mul_free_tag;
  logic              issue, add_alloc, mul_alloc;

  logic              add_disp, mul_disp;
  logic [DATA_W-1:0] add_da, add_db, mul_da, mul_db;
  tag_t              add_dtag, mul_dtag;

  logic              add_unit_free, mul_unit_free;
  logic              add_req, mul_req, add_grant, mul_grant;
  logic [DATA_W-1:0] add_res, mul_res;
  tag_t              add_rtag, mul_rtag;

  assign iq_ready  = (iq_op == OP_MUL) ? mul_free_slot : add_free_slot;
  assign iq_tag    = (iq_op == OP_MUL) ? mul_free_tag  : add_free_tag;
  assign issue     = iq_valid && iq_ready;
  assign add_alloc = issue && (iq_op == OP_ADD);
  assign mul_alloc = issue && (iq_op == OP_MUL);

  // Result bus: the lower producer tag wins, the other unit holds
  always_comb begin
    add_grant = add_req && (!mul_req || (add_rtag < mul_rtag));
    mul_grant = mul_req && !add_grant;
    cdb_valid = add_req || mul_req;
    cdb_tag   = add_grant ? add_rtag : mul_rtag;
    cdb_data  = add_grant ? add_res  : mul_res;
  end

  tsched_regstat #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_en   (issue),
    .iss_dst  (iq_dst),
    .iss_tag  (iq_tag),
    .src1_idx (iq_src1),
    .src2_idx (iq_src2),
    .s1_rdy   (s1_rdy),
    .s1_data  (s1_data),
    .s1_tag   (s1_tag),
    .s2_rdy   (s2_rdy),
    .s2_data  (s2_data),
    .s2_tag   (s2_tag),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data),
    .rd_idx   (rd_idx),
    .rd_busy  (rd_busy),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data)
  );

  tsched_rs_bank #(.NST(ADD_RS), .BASE(ADD_BASE), .DATA_W(DATA_W)) u_add_rs (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (add_alloc),
    .a1_rdy   (s1_rdy),
    .a1_data  (s1_data),
    .a1_tag   (s1_tag),
    .a2_rdy   (s2_rdy),
    .a2_data  (s2_data),
    .a2_tag   (s2_tag),
    .has_free (add_free_slot),
    .free_tag (add_free_tag),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data),
    .unit_free(add_unit_free),
    .disp_en  (add_disp),
    .disp_a   (add_da),
    .disp_b   (add_db),
    .disp_tag (add_dtag)
  );

  tsched_rs_bank #(.NST(MUL_RS), .BASE(MUL_BASE), .DATA_W(DATA_W)) u_mul_rs (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (mul_alloc),
    .a1_rdy   (s1_rdy),
    .a1_data  (s1_data),
    .a1_tag   (s1_tag),
    .a2_rdy   (s2_rdy),
    .a2_data  (s2_data),
    .a2_tag   (s2_tag),
    .has_free (mul_free_slot),
    .free_tag (mul_free_tag),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data),
    .unit_free(mul_unit_free),
    .disp_en  (mul_disp),
    .disp_a   (mul_da),
    .disp_b   (mul_db),
    .disp_tag (mul_dtag)
  );

  tsched_fu #(.LAT(ADD_LAT), .IS_MUL(1'b0), .DATA_W(DATA_W)) u_add_fu (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (add_disp),
    .op_a   (add_da),
    .op_b   (add_db),
    .op_tag (add_dtag),
    .grant  (add_grant),
    .free   (add_unit_free),
    .req    (add_req),
    .res    (add_res),
    .res_tag(add_rtag)
  );

  tsched_fu #(.LAT(MUL_LAT), .IS_MUL(1'b1), .DATA_W(DATA_W)) u_mul_fu (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (mul_disp),
    .op_a   (mul_da),
    .op_b   (mul_db),
    .op_tag (mul_dtag),
    .grant  (mul_grant),
    .free   (mul_unit_free),
    .req    (mul_req),
    .res    (mul_res),
    .res_tag(mul_rtag)
  );

  AST_CDB_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag >= TAG_W'(ADD_BASE)) && (cdb_tag < TAG_W'(MUL_BASE + MUL_RS))); // R3
  AST_ISSUE_CLASS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    mul_alloc |-> (iq_tag >= TAG_W'(MUL_BASE))); // R3

endmodule

// File: tb/tsched_core_tb.sv
`timescale 1ns/1ps
module tsched_core_tb;
  import tsched_pkg::*;

  localparam int NREG = 8;
  localparam int DW   = 16;

  logic             clk;
  logic             rst_n;
  logic             iq_valid;
  logic             iq_op;
  logic [2:0]       iq_dst, iq_src1, iq_src2;
  logic             iq_ready;
  logic [TAG_W-1:0] iq_tag;
  logic             cdb_valid;
  logic [TAG_W-1:0] cdb_tag;
  logic [DW-1:0]    cdb_data;
  logic [2:0]       rd_idx;
  logic             rd_busy;
  logic [TAG_W-1:0] rd_tag;
  logic [DW-1:0]    rd_data;

  int            n_cmp;
  int            n_bad;
  logic [DW-1:0] refr [NREG];
  logic [DW-1:0] exp_q [16][$];
  logic [DW-1:0] mon_e;
  bit            done;

  tsched_core u_dut (
    .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_op(iq_op),
    .iq_dst(iq_dst), .iq_src1(iq_src1), .iq_src2(iq_src2),
    .iq_ready(iq_ready), .iq_tag(iq_tag), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_data(cdb_data), .rd_idx(rd_idx),
    .rd_busy(rd_busy), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: every broadcast is popped against the tag's expected queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cdb_valid === 1'b1) begin
      if (exp_q[cdb_tag].size() == 0) begin
        chk(1'b0, "R10", "broadcast with no pending item", int'(cdb_tag), 0);
      end else begin
        mon_e = exp_q[cdb_tag].pop_front();
        chk(cdb_data == mon_e, "R6", "broadcast value", int'(cdb_data), int'(mon_e));
      end
    end
  end

  // Driver: called at a falling edge; waits while stalled, then commits
  task automatic issue_now(input logic op, input int d, input int s1, input int s2,
                           output logic [TAG_W-1:0] t);
    logic [DW-1:0] v;
    iq_valid = 1'b1;
    iq_op    = op;
    iq_dst   = 3'(d);
    iq_src1  = 3'(s1);
    iq_src2  = 3'(s2);
    #1;
    while (iq_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    t = iq_tag;
    v = op ? 16'(refr[s1] * refr[s2]) : 16'(refr[s1] + refr[s2]);
    exp_q[t].push_back(v);
    refr[d] = v;
    @(posedge clk);
    #1;
    iq_valid = 1'b0;
  endtask

  task automatic issue(input logic op, input int d, input int s1, input int s2,
                       output logic [TAG_W-1:0] t);
    @(negedge clk);
    issue_now(op, d, s1, s2, t);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] t, ta, tm, tb;
    logic [31:0]      lcg;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; iq_valid = 1'b0; iq_op = 1'b0;
    iq_dst = '0; iq_src1 = '0; iq_src2 = '0; rd_idx = '0;
    for (int i = 0; i < NREG; i++) refr[i] = DW'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(rd_busy == 1'b0 && rd_tag == '0, "R1", "register not pending", int'(rd_busy), 0);
      chk(rd_data == DW'(i), "R1", "register reset value", int'(rd_data), i);
    end
    chk(cdb_valid == 1'b0, "R1", "bus idle", int'(cdb_valid), 0);
    iq_op = 1'b0; #1;
    chk(iq_ready == 1'b1, "R1", "add class accepted", int'(iq_ready), 1);
    iq_op = 1'b1; #1;
    chk(iq_ready == 1'b1, "R1", "mul class accepted", int'(iq_ready), 1);

    // R4 R5 R6: lone add, timing and register update
    rd_idx = 3'd1;
    issue(OP_ADD, 1, 2, 3, t);
    chk(t == 4'd8, "R3", "first adder slot tag", int'(t), 8);
    @(negedge clk);
    chk(rd_busy == 1'b1 && rd_tag == t, "R4", "dst pending on slot", int'(rd_tag), int'(t));
    chk(cdb_valid == 1'b0, "R5", "no early add result", int'(cdb_valid), 0);
    edges(1);
    chk(cdb_valid == 1'b0, "R5", "no add result at k+1", int'(cdb_valid), 0);
    edges(1);
    chk(cdb_valid == 1'b1 && cdb_tag == t, "R5", "add result after k+2", int'(cdb_tag), int'(t));
    chk(cdb_data == 16'd5, "R6", "add value", int'(cdb_data), 5);
    edges(1);
    chk(rd_busy == 1'b0 && rd_data == 16'd5, "R6", "register captured", int'(rd_data), 5);

    // R5: lone multiply latency
    edges(10);
    issue(OP_MUL, 4, 2, 3, t);
    chk(t == 4'd11, "R3", "first multiplier slot tag", int'(t), 11);
    edges(3);
    chk(cdb_valid == 1'b0, "R5", "no mul result at k+3", int'(cdb_valid), 0);
    edges(1);
    chk(cdb_valid == 1'b1 && cdb_tag == t && cdb_data == 16'd6, "R5",
        "mul result after k+4", int'(cdb_data), 6);

    // R9 then R8: collision, then issue on the delayed broadcast
    edges(10);
    issue(OP_MUL, 5, 2, 2, tm);
    @(posedge clk);
    issue(OP_ADD, 6, 3, 3, ta);
    edges(2);
    chk(cdb_valid == 1'b1 && cdb_tag == ta, "R9", "lower tag wins bus", int'(cdb_tag), int'(ta));
    edges(1);
    chk(cdb_valid == 1'b1 && cdb_tag == tm && cdb_data == 16'd4, "R9",
        "held mul result next cycle", int'(cdb_tag), int'(tm));
    issue_now(OP_ADD, 7, 5, 1, tb);
    edges(2);
    chk(cdb_valid == 1'b1 && cdb_tag == tb, "R8", "bypassed source ready at once",
        int'(cdb_tag), int'(tb));
    chk(cdb_data == refr[7], "R8", "bypassed value used", int'(cdb_data), int'(refr[7]));

    // R7: newer writer of R1 must survive the older broadcast
    edges(10);
    rd_idx = 3'd1;
    issue(OP_ADD, 1, 2, 3, ta);
    issue(OP_MUL, 1, 1, 3, tm);
    edges(2);
    chk(rd_busy == 1'b1 && rd_tag == tm, "R7", "stale broadcast ignored", int'(rd_tag), int'(tm));
    edges(12);
    chk(rd_busy == 1'b0 && rd_data == refr[1], "R7", "newer writer value", int'(rd_data),
        int'(refr[1]));

    // R2 R3: multiplier slots full, refused instruction, slot reuse
    edges(5);
    issue(OP_MUL, 3, 4, 4, t);
    issue(OP_MUL, 4, 5, 5, t);
    issue(OP_MUL, 6, 6, 6, t);
    @(negedge clk);
    rd_idx = 3'd0;
    iq_valid = 1'b1; iq_op = 1'b1; iq_dst = 3'd0; iq_src1 = 3'd1; iq_src2 = 3'd1;
    #1;
    chk(iq_ready == 1'b0, "R2", "stall when mul slots full", int'(iq_ready), 0);
    iq_op = 1'b0; #1;
    chk(iq_ready == 1'b1, "R2", "add class still open", int'(iq_ready), 1);
    iq_op = 1'b1;
    @(negedge clk); #1;
    chk(rd_busy == 1'b0, "R2", "refused dst untouched", int'(rd_busy), 0);
    issue_now(OP_MUL, 0, 1, 1, t);
    chk(t == 4'd11, "R3", "freed lowest slot reused", int'(t), 11);

    // R10: pseudo-random program
    edges(30);
    lcg = 32'h1234_5678;
    for (int n = 0; n < 60; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      issue(lcg[31], int'(lcg[22:20]), int'(lcg[18:16]), int'(lcg[14:12]), t);
    end

    edges(300);
    for (int q = 0; q < 16; q++)
      chk(exp_q[q].size() == 0, "R10", "all results broadcast", exp_q[q].size(), 0);
    for (int i = 0; i < NREG; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(rd_busy == 1'b0, "R10", "register settled", int'(rd_busy), 0);
      chk(rd_data == refr[i], "R10", "final register value", int'(rd_data), int'(refr[i]));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule